// File: doc/BRIEF.md
# DRAM Refresh and Scrub Sequencer

This block keeps DRAM contents alive and slowly sweeps them for latent errors. A free-running interval timer raises a refresh request at one of two programmable rates, chosen by a fast-rate input. Each request becomes a burst of four row-strobe-only refresh cycles. The row strobe goes to both DRAM blocks at once, and the row address steps after every cycle.

One of the four cycles in each burst is also a scrub. The column strobe is driven to one block only, with the read enable first and then the write enable. Together these form a read-modify-write of one location; the correction logic around the block works on the data.

The scrub location moves along several axes. When the row address wraps, the scrubbed block swaps. Every second row wrap, the scrub moves to the next cycle of the burst. Every eighth row wrap, the column address steps. Each column wrap advances a 2-bit sweep counter that is brought out for software to read. A request that arrives while a burst is running is held and served as soon as the burst ends.

Top module: `dram_refresh_scrub`

## Requirements
- R1: After reset, no strobe and no done is active, and the row, column and sweep counter are zero. The first scrub goes to block A (cas_o bit 0) in the first cycle of a burst.
- R2: The interval timer raises a request every NORM_RELOAD clocks while fast_i is 0 and every FAST_RELOAD clocks while fast_i is 1, counting from reset. A burst starts the clock after a request is seen while idle.
- R3: A burst has four cycles. Each is a run of clocks with both bits of ras_o high, followed by PRE_CLKS clocks with ras_o low. A cycle without a scrub keeps ras_o high for RAS_CLKS clocks.
- R4: In exactly one cycle per burst, exactly one bit of cas_o is high while ras_o is high. The cycle has OE_CLKS clocks of oe_o, then WE_CLKS clocks of we_o, so it lasts OE_CLKS+WE_CLKS clocks. oe_o and we_o are never high together.
- R5: The row address increments by one at the end of each cycle's precharge, wrapping from all ones to zero.
- R6: Each row wrap swaps the scrubbed block between A (cas_o bit 0) and B (cas_o bit 1).
- R7: On every second row wrap, the scrub cycle moves to the next of the four cycles, going from the fourth back to the first.
- R8: On every eighth row wrap, the column address increments by one, wrapping from all ones to zero.
- R9: Each column wrap increments the 2-bit sweep counter sc_o modulo 4.
- R10: A request that arrives during a burst is not lost. The next burst then starts one idle clock after the previous burst's done.
- R11: done_o is high for exactly the last precharge clock of the fourth cycle of each burst, and the following clock is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_i | input | 1 | Selects the short refresh interval |
| ras_o | output | 2 | Row strobe, bit 0 block A, bit 1 block B, active high |
| cas_o | output | 2 | Column strobe to the scrubbed block, bit 0 A, bit 1 B |
| oe_o | output | 1 | Read enable during the scrub cycle |
| we_o | output | 1 | Write enable during the scrub cycle |
| row_o | output | ROW_W | Row address |
| col_o | output | COL_W | Scrub column address |
| sc_o | output | 2 | Column sweep counter |
| done_o | output | 1 | One-clock pulse at the end of a burst |

## Verification
The block first runs at the normal interval, which leaves idle gaps between bursts, so the start time of each burst shows whether the timer counts correctly. It then runs at a fast interval shorter than a burst, which makes requests arrive mid-burst; back-to-back bursts with a one-clock gap show that held requests survive. The final long run at the normal rate is long enough, with small row and column widths, to cross many row wraps, several column wraps and a full wrap of the sweep counter. Along the way the block swap, slot rotation and counter carries are all compared with a behavioural model on every clock.

// File: rtl/dram_rs_pkg.sv
package dram_rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_PRE  = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_timer.sv
module rs_timer #(
  parameter int unsigned NORM_RELOAD = 6000,
  parameter int unsigned FAST_RELOAD = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned MAXR  = (NORM_RELOAD > FAST_RELOAD) ? NORM_RELOAD : FAST_RELOAD;
  localparam int unsigned CNT_W = $clog2(MAXR + 1);
  localparam logic [CNT_W-1:0] NORM_LIM = CNT_W'(NORM_RELOAD - 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_RELOAD - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = fast_i ? FAST_LIM : NORM_LIM;
    tick_o = (cnt_q >= lim);
    cnt_d  = tick_o ? '0 : cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rs_position.sv
module rs_position #(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             blk_o,
  output logic [1:0]       slot_o,
  output logic [1:0]       sc_o
);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [2:0]       wrap_q, wrap_d;
  logic [1:0]       slot_q, slot_d, sc_q, sc_d;
  logic             blk_q, blk_d;
  logic             row_wrap, col_step, col_wrap;

  always_comb begin
    row_wrap = step_i & (&row_q);
    col_step = row_wrap & (&wrap_q);
    col_wrap = col_step & (&col_q);
    row_d    = step_i   ? row_q + ROW_ONE : row_q;
    blk_d    = row_wrap ? ~blk_q : blk_q;
    wrap_d   = row_wrap ? wrap_q + 3'd1 : wrap_q;
    slot_d   = (row_wrap & wrap_q[0]) ? slot_q + 2'd1 : slot_q;
    col_d    = col_step ? col_q + COL_ONE : col_q;
    sc_d     = col_wrap ? sc_q + 2'd1 : sc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      wrap_q <= '0;
      slot_q <= '0;
      sc_q   <= '0;
      blk_q  <= 1'b0;
    end else if (step_i) begin
      row_q  <= row_d;
      col_q  <= col_d;
      wrap_q <= wrap_d;
      slot_q <= slot_d;
      sc_q   <= sc_d;
      blk_q  <= blk_d;
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign blk_o  = blk_q;
  assign slot_o = slot_q;
  assign sc_o   = sc_q;
endmodule

// File: rtl/rs_burst.sv
module rs_burst
  import dram_rs_pkg::*;
#(
  parameter int unsigned RAS_CLKS = 4,
  parameter int unsigned PRE_CLKS = 3,
  parameter int unsigned OE_CLKS  = 2,
  parameter int unsigned WE_CLKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] slot_i,
  input  logic       blk_i,
  output logic       ras_o,
  output logic [1:0] cas_o,
  output logic       oe_o,
  output logic       we_o,
  output logic       step_o,
  output logic       done_o
);
  localparam int unsigned SCR_CLKS = OE_CLKS + WE_CLKS;
  localparam int unsigned M1   = (RAS_CLKS > SCR_CLKS) ? RAS_CLKS : SCR_CLKS;
  localparam int unsigned MAXP = (M1 > PRE_CLKS) ? M1 : PRE_CLKS;
  localparam int unsigned PH_W = $clog2(MAXP + 1);
  localparam logic [PH_W-1:0] PH_ONE   = PH_W'(1);
  localparam logic [PH_W-1:0] RAS_LAST = PH_W'(RAS_CLKS - 1);
  localparam logic [PH_W-1:0] SCR_LAST = PH_W'(SCR_CLKS - 1);
  localparam logic [PH_W-1:0] PRE_LAST = PH_W'(PRE_CLKS - 1);
  localparam logic [PH_W-1:0] OE_END   = PH_W'(OE_CLKS);

  rs_state_e       st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [1:0]      slot_q, slot_d;
  logic            pend_q, pend_d;
  logic            scrub_now, act_last, pre_last, start, cas_act;

  always_comb begin
    scrub_now = (slot_q == slot_i);
    act_last  = scrub_now ? (ph_q == SCR_LAST) : (ph_q == RAS_LAST);
    pre_last  = (ph_q == PRE_LAST);
    start     = (st_q == ST_IDLE) & pend_q;
    pend_d    = tick_i | (pend_q & ~start);
  end

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    slot_d = slot_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_q) begin
          st_d   = ST_ACT;
          ph_d   = '0;
          slot_d = '0;
        end
      end
      ST_ACT: begin
        if (act_last) begin
          st_d = ST_PRE;
          ph_d = '0;
        end else begin
          ph_d = ph_q + PH_ONE;
        end
      end
      ST_PRE: begin
        if (pre_last) begin
          ph_d = '0;
          if (slot_q == 2'd3) begin
            st_d = ST_IDLE;
          end else begin
            st_d   = ST_ACT;
            slot_d = slot_q + 2'd1;
          end
        end else begin
          ph_d = ph_q + PH_ONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      slot_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      slot_q <= slot_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    ras_o   = (st_q == ST_ACT);
    cas_act = ras_o & scrub_now;
    cas_o   = cas_act ? (blk_i ? 2'b10 : 2'b01) : 2'b00;
    oe_o    = cas_act & (ph_q < OE_END);
    we_o    = cas_act & (ph_q >= OE_END);
    step_o  = (st_q == ST_PRE) & pre_last;
    done_o  = step_o & (slot_q == 2'd3);
  end
endmodule

// File: rtl/dram_refresh_scrub.sv
module dram_refresh_scrub #(
  parameter int unsigned ROW_W       = 10,
  parameter int unsigned COL_W       = 10,
  parameter int unsigned NORM_RELOAD = 6000,
  parameter int unsigned FAST_RELOAD = 3000,
  parameter int unsigned RAS_CLKS    = 4,
  parameter int unsigned PRE_CLKS    = 3,
  parameter int unsigned OE_CLKS     = 2,
  parameter int unsigned WE_CLKS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_i,
  output logic [1:0]       ras_o,
  output logic [1:0]       cas_o,
  output logic             oe_o,
  output logic             we_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [1:0]       sc_o,
  output logic             done_o
);
  logic       tick, ras, step, blk;
  logic [1:0] slot;

  rs_timer #(.NORM_RELOAD(NORM_RELOAD), .FAST_RELOAD(FAST_RELOAD)) u_timer (
    .clk(clk), .rst_n(rst_n), .fast_i(fast_i), .tick_o(tick)
  );

  rs_burst #(.RAS_CLKS(RAS_CLKS), .PRE_CLKS(PRE_CLKS),
             .OE_CLKS(OE_CLKS), .WE_CLKS(WE_CLKS)) u_burst (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .slot_i(slot), .blk_i(blk),
    .ras_o(ras), .cas_o(cas_o), .oe_o(oe_o), .we_o(we_o),
    .step_o(step), .done_o(done_o)
  );

  rs_position #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step_i(step), .row_o(row_o), .col_o(col_o),
    .blk_o(blk), .slot_o(slot), .sc_o(sc_o)
  );

  assign ras_o = {ras, ras};
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ras_o,
  input logic [1:0]       cas_o,
  input logic             oe_o,
  input logic             we_o,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o,
  input logic [1:0]       sc_o,
  input logic             done_o
);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  // R4
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_o && we_o));
  // R4
  we_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_o) |-> $past(oe_o));
  // R4
  cas_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cas_o));
  // R3
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_o != 2'b00) |-> (ras_o == 2'b11));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (ras_o == 2'b00));
  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_o != $past(row_o)) |-> (row_o == $past(row_o) + ROW_ONE));
  // R8
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_o != $past(col_o)) |-> (col_o == $past(col_o) + COL_ONE));
  // R9
  sc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_o != $past(sc_o)) |-> (sc_o == $past(sc_o) + 2'd1));
endmodule

bind dram_refresh_scrub rs_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_o(ras_o), .cas_o(cas_o), .oe_o(oe_o),
  .we_o(we_o), .row_o(row_o), .col_o(col_o), .sc_o(sc_o), .done_o(done_o)
);

// File: tb/dram_refresh_scrub_tb.sv
module dram_refresh_scrub_tb;
  localparam int ROW_W = 3, COL_W = 2, NORM = 40, FAST = 12;
  localparam int RAS = 3, PRE = 2, OE = 2, WE = 3;

  logic clk, rst_n, fast_i;
  logic [1:0] ras_o, cas_o, sc_o;
  logic oe_o, we_o, done_o;
  logic [ROW_W-1:0] row_o;
  logic [COL_W-1:0] col_o;

  dram_refresh_scrub #(.ROW_W(ROW_W), .COL_W(COL_W), .NORM_RELOAD(NORM),
    .FAST_RELOAD(FAST), .RAS_CLKS(RAS), .PRE_CLKS(PRE), .OE_CLKS(OE),
    .WE_CLKS(WE)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_i(fast_i), .ras_o(ras_o), .cas_o(cas_o),
    .oe_o(oe_o), .we_o(we_o), .row_o(row_o), .col_o(col_o), .sc_o(sc_o),
    .done_o(done_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // reference model: entry bits {ras, casB, casA, oe, we, endcyc, done}
  logic [6:0] bq[$];
  int tmr, pend, row, col, blk, slot, wraps, sc;

  task automatic push_burst();
    for (int k = 0; k < 4; k++) begin
      if (k == slot)
        for (int p = 0; p < OE + WE; p++)
          bq.push_back({1'b1, blk[0], ~blk[0], p < OE, p >= OE, 2'b00});
      else
        for (int p = 0; p < RAS; p++) bq.push_back(7'b1000000);
      for (int p = 0; p < PRE; p++)
        bq.push_back({5'b0, p == PRE - 1, (p == PRE - 1) && (k == 3)});
    end
  endtask

  task automatic advance();
    row = (row + 1) % (1 << ROW_W);
    if (row == 0) begin
      blk = 1 - blk;
      wraps++;
      if (wraps % 2 == 0) slot = (slot + 1) % 4;
      if (wraps % 8 == 0) begin
        col = (col + 1) % (1 << COL_W);
        if (col == 0) sc = (sc + 1) % 4;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete();
      tmr = 0; pend = 0; row = 0; col = 0; blk = 0; slot = 0; wraps = 0; sc = 0;
    end else begin
      int tick, was_idle, started;
      logic [6:0] e;
      tick = (tmr >= (fast_i ? FAST : NORM) - 1);
      tmr = tick ? 0 : tmr + 1;
      was_idle = (bq.size() == 0);
      if (!was_idle) begin
        e = bq.pop_front();
        if (e[1]) advance();
      end
      started = was_idle && pend;
      if (started) push_burst();
      pend = tick || (pend && !started);
    end
  end

  int cas_clks = 0, dones = 0, done_at = -10, cyc = 0;
  bit in_fast = 0, saw_b = 0, saw_a = 0, sc_hit3 = 0, sc_wrapped = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [6:0] x;
      x = (bq.size() != 0) ? bq[0] : 7'b0;
      chk("R2 R3 R10 ras", ras_o, {x[6], x[6]});
      chk("R4 R6 R7 cas", cas_o, {x[5], x[4]});
      chk("R4 oe", oe_o, x[3]);
      chk("R4 we", we_o, x[2]);
      chk("R5 row", row_o, row);
      chk("R8 col", col_o, col);
      chk("R9 sc", sc_o, sc);
      chk("R11 done", done_o, x[0]);
      if (cas_o[0]) saw_a = 1;
      if (cas_o[1]) saw_b = 1;
      if (sc_o == 2'd3) sc_hit3 = 1;
      if (sc_hit3 && sc_o == 2'd0) sc_wrapped = 1;
      if (cas_o != 2'b00) cas_clks++;
      if (in_fast && dones > 2 && cyc == done_at + 2)
        chk("R10 back-to-back start", ras_o, 3);
      if (done_o) begin
        chk("R4 scrub clocks per burst", cas_clks, OE + WE);
        cas_clks = 0;
        dones++;
        done_at = cyc;
      end
    end
  end

  initial begin
    rst_n = 1'b0; fast_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ras", ras_o, 0);
    chk("R1 cas", cas_o, 0);
    chk("R1 row", row_o, 0);
    chk("R1 col", col_o, 0);
    chk("R1 sc", sc_o, 0);
    chk("R1 done", done_o, 0);
    rst_n = 1'b1;
    repeat (4000) @(negedge clk);
    fast_i = 1'b1; in_fast = 1; dones = 0;
    repeat (3000) @(negedge clk);
    fast_i = 1'b0; in_fast = 0;
    repeat (12000) @(negedge clk);
    chk("R6 both blocks scrubbed", saw_a && saw_b, 1);
    chk("R9 sweep counter wrapped", sc_wrapped, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles expected under %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule